// File: doc/BRIEF.md
# Dual-Mode Eight-Bit Pulse Accumulator

This block accumulates counts from a single external input pin into an eight-bit counter. In event mode it adds one for each active edge of the pin, where a polarity control picks rising or falling edges. In gated mode it adds one on every 64th system clock for as long as the pin stays away from an inhibit level. The same polarity control sets that inhibit level. The pin is synchronized to the system clock before any edge is detected. The divide-by-64 tick runs freely from reset and is never restarted.

Software can load the counter in any cycle. It sees the count at all times on a dedicated output. Two sticky flags report events. The overflow flag marks a wrap from all ones to zero, so loading the two's complement of N raises it after N counts. The edge flag marks the selected edge in event mode, and in gated mode the trailing edge that closes an active period. Each flag has a one-cycle clear strobe, an enable, and an interrupt output. A unit enable freezes counting and flag setting while it is low.

Top module: `pulse_acc`

## Requirements
- R1: After reset the counter reads 0x00, both flags read 0 and both interrupt outputs are low.
- R2: In event mode (`mode_gated`=0) the counter adds one for each synchronized rising edge of `pin_in` when `pol`=1, or for each falling edge when `pol`=0. Edges of the other direction do not change it, and it never moves by more than one per cycle.
- R3: In gated mode (`mode_gated`=1) the counter adds one on every 64th clock while the synchronized pin differs from `pol`, and holds while the pin equals `pol`. The 64-clock tick runs from reset without restart, so any window of 64·N clocks with the pin active yields exactly N counts.
- R4: With `en`=0 the counter holds (except for loads) and neither flag is set.
- R5: An increment from 0xFF to 0x00 sets `ovf_flag`. Loading 256−N makes the flag rise on the Nth counted event.
- R6: `edg_flag` is set by a rising edge when `pol`=1 and by a falling edge when `pol`=0, in both modes. In gated mode this is the edge that ends an active period. The opposite edge leaves it clear.
- R7: A one-cycle `ovf_clr` or `edg_clr` pulse clears its flag. If a set event falls in the same cycle as the clear, the flag ends set.
- R8: `cnt_wr` loads `cnt_wdata` on the next clock edge and takes priority over an increment in that cycle.
- R9: `ovf_irq` is high only while both `ovf_flag` and `ovf_ie` are high, and `edg_irq` likewise with `edg_flag` and `edg_ie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Asynchronous accumulator input pin |
| en | input | 1 | Unit enable |
| mode_gated | input | 1 | 0 = event counting, 1 = gated time counting |
| pol | input | 1 | Counted edge (event mode) / inhibit level (gated mode) |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | CNT_W | Counter load value |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| edg_clr | input | 1 | Edge flag clear strobe |
| ovf_ie | input | 1 | Overflow interrupt enable |
| edg_ie | input | 1 | Edge interrupt enable |
| cnt_q | output | CNT_W | Current counter value |
| ovf_flag | output | 1 | Overflow flag |
| edg_flag | output | 1 | Input edge flag |
| ovf_irq | output | 1 | Overflow interrupt request |
| edg_irq | output | 1 | Edge interrupt request |

## Verification
The bench builds the block with its defaults: an eight-bit counter, a six-bit divider (tick every 64 clocks) and a two-stage synchronizer. The small divider keeps gated windows of 128 and 320 clocks short, so exact tick counts can be checked whatever the divider phase is. With the eight-bit width, the 0xFF-to-0x00 wrap and the two's-complement preload can be reached with one to three edges. The two-stage synchronizer fixes the latency from a pin change to a count. This lets the bench place a load strobe or a flag clear in exactly the cycle where an increment or a flag set lands.

// File: rtl/pulse_acc.sv
module pulse_acc #(
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 6,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             en,
  input  logic             mode_gated,
  input  logic             pol,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ovf_clr,
  input  logic             edg_clr,
  input  logic             ovf_ie,
  input  logic             edg_ie,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_flag,
  output logic             edg_flag,
  output logic             ovf_irq,
  output logic             edg_irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC_N-1:0] sync_q;
  logic              pin_d;
  logic [DIV_W-1:0]  div_q;
  logic              pin_s, rise, fall, act_edge, tick, gate_open, inc, ovf_set, edg_set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q <= '0;
      pin_d  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], pin_in};
      pin_d  <= pin_s;
    end

  assign pin_s = sync_q[SYNC_N-1];
  assign rise  = pin_s & ~pin_d;
  assign fall  = ~pin_s & pin_d;

  // Selected edge in event mode equals the trailing edge of an active period in gated mode.
  assign act_edge = pol ? rise : fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;

  assign tick      = &div_q;
  assign gate_open = pin_s ^ pol;
  assign inc       = en & (mode_gated ? (tick & gate_open) : act_edge);
  assign ovf_set   = inc & ~cnt_wr & (cnt_q == CNT_MAX);
  assign edg_set   = en & act_edge;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_wr) cnt_q <= cnt_wdata;
    else if (inc)    cnt_q <= cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      edg_flag <= 1'b0;
    end else begin
      ovf_flag <= ovf_set | (ovf_flag & ~ovf_clr);
      edg_flag <= edg_set | (edg_flag & ~edg_clr);
    end

  assign ovf_irq = ovf_flag & ovf_ie;
  assign edg_irq = edg_flag & edg_ie;
endmodule

// File: rtl/pulse_acc_chk.sv
module pulse_acc_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic             ovf_clr,
  input logic             ovf_ie,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ovf_flag,
  input logic             edg_flag,
  input logic             ovf_irq
);
  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(cnt_wdata));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> $stable(cnt_q));

  a_r4_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !$rose(edg_flag) && !$rose(ovf_flag));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1 && !cnt_wr) ##1 (cnt_q == '0) |-> ovf_flag);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && cnt_q != '1) |=> !ovf_flag);

  a_r9_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_irq) |-> ovf_ie);
endmodule

bind pulse_acc pulse_acc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
  .ovf_clr(ovf_clr), .ovf_ie(ovf_ie), .cnt_q(cnt_q), .ovf_flag(ovf_flag),
  .edg_flag(edg_flag), .ovf_irq(ovf_irq)
);

// File: tb/pulse_acc_tb.sv
module pulse_acc_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       pin_in = 1'b0, en = 1'b0, mode_gated = 1'b0, pol = 1'b1;
  logic       cnt_wr = 1'b0, ovf_clr = 1'b0, edg_clr = 1'b0, ovf_ie = 1'b0, edg_ie = 1'b0;
  logic [7:0] cnt_wdata = 8'h00;
  logic [7:0] cnt_q;
  logic       ovf_flag, edg_flag, ovf_irq, edg_irq;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  pulse_acc u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .en(en), .mode_gated(mode_gated), .pol(pol),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .ovf_clr(ovf_clr), .edg_clr(edg_clr),
    .ovf_ie(ovf_ie), .edg_ie(edg_ie), .cnt_q(cnt_q), .ovf_flag(ovf_flag),
    .edg_flag(edg_flag), .ovf_irq(ovf_irq), .edg_irq(edg_irq)
  );

  // {start level, pol, transitions[5:0], expected count}
  localparam logic [15:0] VEC [8] = '{
    {1'b0, 1'b1, 6'd3, 8'd2}, {1'b0, 1'b0, 6'd3, 8'd1},
    {1'b1, 1'b1, 6'd3, 8'd1}, {1'b1, 1'b0, 6'd3, 8'd2},
    {1'b0, 1'b1, 6'd8, 8'd4}, {1'b1, 1'b0, 6'd1, 8'd1},
    {1'b1, 1'b1, 6'd1, 8'd0}, {1'b0, 1'b0, 6'd0, 8'd0}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic load(input logic [7:0] v);
    cnt_wdata = v; cnt_wr = 1'b1; step(1); cnt_wr = 1'b0;
  endtask

  task automatic clr_flags;
    ovf_clr = 1'b1; edg_clr = 1'b1; step(1); ovf_clr = 1'b0; edg_clr = 1'b0;
  endtask

  task automatic toggle_n(input int n);
    for (int i = 0; i < n; i++) begin pin_in = ~pin_in; step(4); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(2);
    // R1 reset state
    chk("R1 cnt", cnt_q, 8'h00);
    chk("R1 flags", {6'b0, ovf_flag, edg_flag}, 8'h00);
    chk("R1 irqs", {6'b0, ovf_irq, edg_irq}, 8'h00);
    rst_n = 1'b1; en = 1'b1; step(2);

    // R2 event-mode vector table
    for (int v = 0; v < 8; v++) begin
      pin_in = VEC[v][15]; pol = VEC[v][14]; step(4);
      load(8'h00);
      toggle_n(int'(VEC[v][13:8]));
      step(2);
      chk($sformatf("R2 vec%0d", v), cnt_q, VEC[v][7:0]);
    end

    // R8 load beats a simultaneous increment
    pol = 1'b1; pin_in = 1'b0; step(4); load(8'h10);
    pin_in = 1'b1; step(2);
    cnt_wdata = 8'h40; cnt_wr = 1'b1; step(1); cnt_wr = 1'b0;
    chk("R8 load value", cnt_q, 8'h40);
    step(3);
    chk("R8 increment dropped", cnt_q, 8'h40);

    // R5 wrap and preload
    pin_in = 1'b0; step(4); clr_flags(); load(8'hFE);
    toggle_n(2);
    chk("R5 at FF no flag", {cnt_q[7:1], ovf_flag}, {7'h7F, 1'b0});
    toggle_n(2);
    chk("R5 wrap cnt", cnt_q, 8'h00);
    chk("R5 wrap flag", {7'b0, ovf_flag}, 8'h01);
    clr_flags(); load(8'hFD);
    toggle_n(4);
    chk("R5 preload 2 of 3", {7'b0, ovf_flag}, 8'h00);
    toggle_n(2);
    chk("R5 preload 3 of 3", {7'b0, ovf_flag}, 8'h01);

    // R9 interrupt gating
    ovf_ie = 1'b0; step(1);
    chk("R9 irq masked", {7'b0, ovf_irq}, 8'h00);
    ovf_ie = 1'b1; step(1);
    chk("R9 irq on", {7'b0, ovf_irq}, 8'h01);

    // R7 clear, and set wins over clear
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    chk("R7 cleared", {7'b0, ovf_flag}, 8'h00);
    chk("R9 irq follows flag", {7'b0, ovf_irq}, 8'h00);
    load(8'hFF); pin_in = 1'b1; step(2);
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    chk("R7 set wins", {7'b0, ovf_flag}, 8'h01);
    chk("R7 set wins cnt", cnt_q, 8'h00);
    ovf_ie = 1'b0;

    // R6 event-mode edge flag
    pin_in = 1'b0; step(4); clr_flags(); edg_ie = 1'b1;
    pin_in = 1'b1; step(4);
    chk("R6 event rising sets", {6'b0, edg_flag, edg_irq}, 8'h03);
    clr_flags(); pin_in = 1'b0; step(4);
    chk("R6 event falling ignored", {7'b0, edg_flag}, 8'h00);

    // R6 gated-mode trailing edge, pol=0 (active high)
    mode_gated = 1'b1; pol = 1'b0; pin_in = 1'b1; step(4); clr_flags();
    chk("R6 gated leading ignored", {7'b0, edg_flag}, 8'h00);
    pin_in = 1'b0; step(4);
    chk("R6 gated trailing sets", {7'b0, edg_flag}, 8'h01);
    edg_ie = 1'b0;

    // R3 gated counting
    pol = 1'b1; pin_in = 1'b0; step(4); load(8'h00); step(320);
    chk("R3 active 320 clk", cnt_q, 8'd5);
    pin_in = 1'b1; step(4); load(8'h00); step(320);
    chk("R3 inhibited", cnt_q, 8'd0);
    pol = 1'b0; step(4); load(8'h07); step(128);
    chk("R3 pol0 active 128 clk", cnt_q, 8'd9);

    // R4 unit disabled
    en = 1'b0; step(2); clr_flags(); load(8'h33); step(200);
    chk("R4 gated hold", cnt_q, 8'h33);
    mode_gated = 1'b0; pol = 1'b1; pin_in = 1'b0; step(4);
    toggle_n(4);
    chk("R4 event hold", cnt_q, 8'h33);
    chk("R4 no flags", {6'b0, ovf_flag, edg_flag}, 8'h00);

    // R1 reset mid-run
    en = 1'b1; toggle_n(2); rst_n = 1'b0; step(1);
    chk("R1 reset again", {cnt_q[7:2], ovf_flag, edg_flag}, 8'h00);
    rst_n = 1'b1; step(2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule